// File: doc/BRIEF.md
# Idle Vote Termination Detector

This block gives a group of message-passing threads a hardware barrier for detecting when their computation has stopped. A thread with nothing left to do makes an idle call that carries a one-bit vote. The block records which threads are idle and what each one voted. It also keeps a count of messages that have been sent but not yet consumed. When every thread is idle and no message is in flight, the block releases all threads at once. Release means the idle call returns true.

The released threads also receive the OR of the recorded votes. A 1 tells the software to start a new time step, and a 0 tells it to enter the finish phase. A message delivered to an idle thread takes that thread out of the barrier. The block gives that thread a wake pulse, so its idle call returns false and it can handle the message. The block covers a single tile. Aggregation across chips is done elsewhere.

Top module: `idle_vote_barrier`

## Requirements
- R1: After reset no thread is idle, the in-flight count is zero, and `release_o` and `wake_o` are low.
- R2: A pulse on `idle_req[i]` marks thread i idle and stores `idle_vote[i]` as its vote. A later request from the same thread before release replaces the stored vote.
- R3: The in-flight count is signed. It rises by one for each `msg_sent` pulse and falls by one for each `msg_consumed` pulse. It is unchanged when both pulses come in the same cycle, and it may go below zero.
- R4: Release needs two things: every thread is idle with the count at zero on two consecutive clock edges, and the deciding cycle has no `msg_sent` or `msg_consumed` pulse. `release_o` goes high in the cycle after the second clock edge at which the condition holds. That is two clock edges after the edge that completes the condition.
- R5: `release_o` is high for exactly one cycle. All idle bits clear on the same edge, so a further release needs fresh requests from every thread.
- R6: While `release_o` is high, `vote_o` is the OR of the stored votes of all threads. 1 means a new time step and 0 means finish.
- R7: A `msg_consumed` pulse delivers a message to the thread whose binary index is on `msg_dst`. If that thread is idle or requesting in that cycle, its idle bit clears and `wake_o[i]` (bit i for thread i) pulses high for one cycle on the next edge. A busy destination gets no wake.
- R8: The stored vote of a woken thread no longer counts. Only the vote from its next request is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | NUM_THREADS | Per-thread idle call pulse |
| idle_vote | input | NUM_THREADS | Per-thread vote sampled with its request |
| msg_sent | input | 1 | One message entered the network |
| msg_consumed | input | 1 | One message delivered to a thread |
| msg_dst | input | TID_W | Binary index of the receiving thread |
| release_o | output | 1 | One-cycle barrier release (idle calls return true) |
| wake_o | output | NUM_THREADS | Per-thread pulse: idle call returns false |
| vote_o | output | 1 | Combined vote, valid with release_o |

## Verification
The bench sends a message pulse during the second cycle of qualification. A design without suppression or without the two-edge wait would release while a message is still moving. It also sends and consumes in the same cycle while all threads are idle, and has a consume come before its send so the count dips below zero. A counter that is unsigned or that lets one pulse win would then never release, or would release too early. Further cases are a request and an arrival for the same thread in the same cycle, where giving the request priority leaves the thread asleep. A vote is overwritten before release and a woken thread's old vote is left stale, which catches a reduction that keeps outdated votes.

// File: rtl/idle_vote_pkg.sv
package idle_vote_pkg;

    // Message-network activity seen in one cycle
    typedef struct packed {
        logic sent;
        logic consumed;
    } net_ev_t;

    // Net change of the in-flight count for one cycle's activity
    function automatic logic signed [1:0] flight_delta(input net_ev_t ev);
        case ({ev.sent, ev.consumed})
            2'b10:   return 2'sd1;
            2'b01:   return -2'sd1;
            default: return 2'sd0;
        endcase
    endfunction

endpackage

// File: rtl/ivb_flight_counter.sv
module ivb_flight_counter
    import idle_vote_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic    clk,
    input  logic    rst,
    input  net_ev_t ev,
    output logic    zero
);
    localparam logic signed [CNT_W-1:0] CNT_MAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CNT_MIN = {1'b1, {(CNT_W-1){1'b0}}};

    logic signed [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + CNT_W'(flight_delta(ev));
    end

    assign zero = (count_q == '0);

    // R3
    balanced_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.sent == ev.consumed) |=> $stable(count_q));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !((ev.sent && !ev.consumed && count_q == CNT_MAX) ||
          (ev.consumed && !ev.sent && count_q == CNT_MIN)));
endmodule

// File: rtl/ivb_idle_tracker.sv
module ivb_idle_tracker #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] idle_req,
    input  logic [NUM_THREADS-1:0] idle_vote,
    input  logic                   arrive,
    input  logic [TID_W-1:0]       arrive_dst,
    input  logic                   fire,
    output logic                   all_idle,
    output logic                   vote_or,
    output logic [NUM_THREADS-1:0] wake_q
);
    logic [NUM_THREADS-1:0] idle_q;
    logic [NUM_THREADS-1:0] vote_q;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic hit;
        assign hit = arrive && (arrive_dst == TID_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                idle_q[t] <= 1'b0;
                vote_q[t] <= 1'b0;
                wake_q[t] <= 1'b0;
            end else begin
                // Arrival wins over a request made in the same cycle
                wake_q[t] <= hit && (idle_q[t] || idle_req[t]);
                if (fire || hit) begin
                    idle_q[t] <= 1'b0;
                end else if (idle_req[t]) begin
                    idle_q[t] <= 1'b1;
                    vote_q[t] <= idle_vote[t];
                end
            end
        end
    end

    assign all_idle = &idle_q;
    assign vote_or  = |(idle_q & vote_q);

    // R7
    wake_only_sleeper_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((wake_q & ~$past(idle_q | idle_req)) == '0));
    // R7
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wake_q));
endmodule

// File: rtl/ivb_release_qual.sv
module ivb_release_qual
    import idle_vote_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    all_idle,
    input  logic    zero,
    input  net_ev_t ev,
    input  logic    vote_or,
    output logic    fire,
    output logic    release_o,
    output logic    vote_o
);
    logic cond;
    logic cond_q;

    assign cond = all_idle && zero;
    assign fire = cond && cond_q && !ev.sent && !ev.consumed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q    <= 1'b0;
            release_o <= 1'b0;
            vote_o    <= 1'b0;
        end else begin
            cond_q    <= cond && !fire;
            release_o <= fire;
            if (fire) vote_o <= vote_or;
        end
    end

    // R5
    release_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        release_o |=> !release_o);
    // R4
    release_qualified_chk: assert property (@(posedge clk) disable iff (rst)
        release_o |-> ($past(cond) && $past(cond, 2) &&
                       !$past(ev.sent) && !$past(ev.consumed)));
endmodule

// File: rtl/idle_vote_barrier.sv
module idle_vote_barrier
    import idle_vote_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int CNT_W = 12,
    parameter int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] idle_req,
    input  logic [NUM_THREADS-1:0] idle_vote,
    input  logic                   msg_sent,
    input  logic                   msg_consumed,
    input  logic [TID_W-1:0]       msg_dst,
    output logic                   release_o,
    output logic [NUM_THREADS-1:0] wake_o,
    output logic                   vote_o
);
    net_ev_t ev;
    logic    all_idle;
    logic    zero;
    logic    vote_or;
    logic    fire;

    assign ev = '{sent: msg_sent, consumed: msg_consumed};

    ivb_flight_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .zero (zero)
    );

    ivb_idle_tracker #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .idle_req   (idle_req),
        .idle_vote  (idle_vote),
        .arrive     (msg_consumed),
        .arrive_dst (msg_dst),
        .fire       (fire),
        .all_idle   (all_idle),
        .vote_or    (vote_or),
        .wake_q     (wake_o)
    );

    ivb_release_qual u_qual (
        .clk       (clk),
        .rst       (rst),
        .all_idle  (all_idle),
        .zero      (zero),
        .ev        (ev),
        .vote_or   (vote_or),
        .fire      (fire),
        .release_o (release_o),
        .vote_o    (vote_o)
    );

    // R5
    no_wake_on_release_chk: assert property (@(posedge clk) disable iff (rst)
        release_o |-> (wake_o == '0));
endmodule

// File: tb/idle_vote_barrier_bench.sv
`timescale 1ns/1ps
module idle_vote_barrier_bench;
    localparam int N = 4;
    localparam int TW = 2;
    localparam int NV = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  idle_req = '0;
    logic [N-1:0]  idle_vote = '0;
    logic          msg_sent = 1'b0;
    logic          msg_consumed = 1'b0;
    logic [TW-1:0] msg_dst = '0;
    logic          release_o;
    logic [N-1:0]  wake_o;
    logic          vote_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    idle_vote_barrier #(.NUM_THREADS(N), .CNT_W(12)) u_idle_vote_barrier (
        .clk(clk), .rst(rst), .idle_req(idle_req), .idle_vote(idle_vote),
        .msg_sent(msg_sent), .msg_consumed(msg_consumed), .msg_dst(msg_dst),
        .release_o(release_o), .wake_o(wake_o), .vote_o(vote_o)
    );

    // Row: req, vote, sent, consumed, dst | expected release, wake, vote
    localparam logic [17:0] VEC [NV] = '{
        {4'b1111,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 0 R2 all idle
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 1 R4 qualifying
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b0}, // 2 R4 release, R6 finish
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 3 R5 one pulse
        {4'b0011,4'b0010,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 4 R2 partial
        {4'b1100,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 5
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 6
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b1}, // 7 R6 continue
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 8 R5
        {4'b0000,4'b0000,1'b1,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 9 R3 in flight
        {4'b1111,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 10
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 11 R4 blocked by count
        {4'b0000,4'b0000,1'b0,1'b1,2'd2, 1'b0,4'b0100,1'b0}, // 12 R7 wake thread 2
        {4'b0100,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 13
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 14
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b0}, // 15 R4
        {4'b1111,4'b1000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 16
        {4'b0000,4'b0000,1'b1,1'b1,2'd0, 1'b0,4'b0001,1'b0}, // 17 R3 both, R7 wake 0
        {4'b0001,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 18
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 19
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b1}, // 20 R6 vote of thread 3
        {4'b1111,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 21
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 22
        {4'b0000,4'b0000,1'b1,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 23 R4 suppressed by send
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 24
        {4'b0000,4'b0000,1'b0,1'b1,2'd1, 1'b0,4'b0010,1'b0}, // 25 R7
        {4'b0010,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 26
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 27
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b0}, // 28
        {4'b0000,4'b0000,1'b0,1'b1,2'd3, 1'b0,4'b0000,1'b0}, // 29 R7 busy, R3 negative
        {4'b1111,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 30
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 31 R3 count -1
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 32
        {4'b0000,4'b0000,1'b1,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 33 back to zero
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b0,4'b0000,1'b0}, // 34
        {4'b0000,4'b0000,1'b0,1'b0,2'd0, 1'b1,4'b0000,1'b0}  // 35
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] r, input logic [N-1:0] v,
                         input logic s, input logic c, input logic [TW-1:0] d);
        idle_req = r; idle_vote = v; msg_sent = s; msg_consumed = c; msg_dst = d;
        @(negedge clk);
    endtask

    task automatic quiet(input int n);
        for (int k = 0; k < n; k++) drive('0, '0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        #(100000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 release after reset", 8'(release_o), 8'd0);
        check("R1 wake after reset", 8'(wake_o), 8'd0);

        for (int i = 0; i < NV; i++) begin
            logic [17:0] row;
            row = VEC[i];
            drive(row[17:14], row[13:10], row[9], row[8], row[7:6]);
            check($sformatf("R4/R5 release row %0d", i), 8'(release_o), 8'(row[5]));
            check($sformatf("R7 wake row %0d", i), 8'(wake_o), 8'(row[4:1]));
            if (row[5]) check($sformatf("R6 vote row %0d", i), 8'(vote_o), 8'(row[0]));
        end

        // R1: reset clears a nonzero in-flight count
        drive('0, '0, 1'b1, 1'b0, '0);
        drive('0, '0, 1'b1, 1'b0, '0);
        rst = 1'b1;
        quiet(2);
        rst = 1'b0;
        drive(4'b1111, 4'b0000, 1'b0, 1'b0, '0);
        quiet(1);
        check("R1 no release yet", 8'(release_o), 8'd0);
        quiet(1);
        check("R1 count zero after reset", 8'(release_o), 8'd1);

        // R7: request and arrival for the same thread in one cycle
        drive('0, '0, 1'b1, 1'b0, '0);
        drive(4'b1111, 4'b0000, 1'b0, 1'b1, 2'd0);
        check("R7 same-cycle wake", 8'(wake_o), 8'b0001);
        quiet(2);
        check("R7 thread 0 not idle", 8'(release_o), 8'd0);
        drive(4'b0001, 4'b0000, 1'b0, 1'b0, '0);
        quiet(2);
        check("R7 release after re-request", 8'(release_o), 8'd1);

        // R2: a later request overwrites the stored vote
        drive(4'b0001, 4'b0001, 1'b0, 1'b0, '0);
        drive(4'b1111, 4'b0000, 1'b0, 1'b0, '0);
        quiet(2);
        check("R2 release", 8'(release_o), 8'd1);
        check("R2 overwritten vote", 8'(vote_o), 8'd0);

        // R8: stale vote of a woken thread ignored
        drive('0, '0, 1'b1, 1'b0, '0);
        drive(4'b1111, 4'b0100, 1'b0, 1'b0, '0);
        drive('0, '0, 1'b0, 1'b1, 2'd2);
        drive(4'b0100, 4'b0000, 1'b0, 1'b0, '0);
        quiet(2);
        check("R8 release", 8'(release_o), 8'd1);
        check("R8 stale vote dropped", 8'(vote_o), 8'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule